// File: doc/BRIEF.md
# Nibble-Sliced Memory Self-Test Controller

This block tests a 256-word, 12-bit memory built from three 4-bit slices: bits [3:0], [7:4] and [11:8]. It runs on its own from reset and repeats forever. Each loop starts with a short screen. The screen uses only the first and last address. It decides, slice by slice, whether bits are stuck at 1 or stuck at 0. When all three slices pass the screen, the block sweeps every address with the same slice patterns. Results appear on active-low status pins: one good/bad flag per slice, a flag that is low while the sweep runs, and a flag that is low when a verdict could be reached.

A 12-bit read cannot be split to show one slice on its own. So when address 0 shows stuck-high and stuck-low bits at the same time, the block gives up on every slice and marks them all untestable. A 2-bit fault code per slice keeps the first fault seen since reset.

The memory port is a plain fixed-timing port, not a stream, and has no back-pressure. Each access takes two cycles. In the first, the block drives `mem_we` high with an address and a data word, and the memory writes at the clock edge. In the second, `mem_we` is low, the address is unchanged, and the block compares `mem_rdata` in that same cycle. The memory must therefore return read data combinationally.

Top module: `nibble_ram_selftest`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `slice_ok_n`, `full_run_n`, `can_test_n`, `fault_code`, `loop_done` and `mem_we` are all 0.
- R2: Every cycle with `mem_we` high is followed by a cycle with `mem_we` low and the same `mem_addr`, in which the read data is compared.
- R3: Each loop first writes 0x000 to address 0x00 and reads it back. Any 1 in the read value sends the loop to the stuck-high branch; otherwise the loop takes the stuck-low branch.
- R4: Stuck-low branch: slice s is written and verified at 0x00 and then at 0xFF, first with 0x5 and then with 0xA placed in its nibble, all other bits 0. Slice s is bad if any bit set in the written pattern reads back 0. A bad slice drives `slice_ok_n[s]`=1 and records code 01; a good slice drives `slice_ok_n[s]`=0.
- R5: Stuck-high branch: slice s is written at 0x00 and 0xFF with all ones except its own nibble (0xFF0, 0xF0F, 0x0FF). Any 1 read back in that nibble makes the slice bad: `slice_ok_n[s]`=1 and code 10. A slice with no such 1 drives `slice_ok_n[s]`=0.
- R6: On entering the stuck-high branch, the block writes 0xFFF to address 0x00 and reads it back. Any 0 in the read value forces `slice_ok_n`=111, sets every code to 11 and sets `can_test_n`=1, and the loop then ends.
- R7: Outside the full sweep, writes go only to 0x00 and 0xFF. A loop holds a pass counter that starts at 3 and is decremented for each slice that passes the stuck-low screen. The sweep runs only when the counter is 0 after the third slice, and `full_run_n` is low exactly while the sweep is in progress.
- R8: The sweep writes and verifies both patterns of each slice at every address from 0x00 to 0xFF. A stuck-low bit found at any single address marks that slice with `slice_ok_n`=1 and code 01.
- R9: `fault_code[2s+1:2s]` holds the fault of slice s: 00 for OK, 01 for stuck low, 10 for stuck high and 11 for untestable. Once a code is nonzero it is never cleared until reset, and a slice flag that later returns to good does not clear it.
- R10: The loop repeats forever. At the end of every loop, `loop_done` is high for exactly one cycle, and during that cycle `full_run_n`=1 and `mem_we`=0.
- R11: A loop that reaches any per-slice verdict drives `can_test_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 12 | Write data |
| mem_we | output | 1 | Write strobe; the next cycle is the read-back |
| mem_rdata | input | 12 | Combinational read data at `mem_addr` |
| slice_ok_n | output | 3 | Per-slice result, 0 = good |
| full_run_n | output | 1 | 0 while the full sweep runs |
| can_test_n | output | 1 | 0 when a verdict could be reached |
| fault_code | output | 6 | Sticky 2-bit code per slice, slice 0 in the low bits |
| loop_done | output | 1 | One-cycle pulse at the end of each loop |

## Verification
The bench injects whole-memory stuck-high and stuck-low masks, plus one fault that exists at a single middle address.

- **Stuck-low faults in the low slice and the high slice.** A design with a mis-placed pattern would flag the wrong slice or miss the fault.
- **Stuck-high faults on one slice and on two slices.** A design that skipped the probe at address 0 would report them as stuck low.
- **A combined stuck-high and stuck-low fault.** A design that did not refuse it would report some slices as good.
- **The fault at a single middle address.** It passes the screen, so only a design that really sweeps every address finds it. A design that ran the sweep after a failed screen would show `full_run_n` low when it should stay high.
- **A fault removed after it has been recorded.** The slice flag must return to good while its code stays set.

// File: rtl/mst_pkg.sv
package mst_pkg;

  typedef enum logic [3:0] {
    ST_START,
    ST_PH_W,
    ST_PH_R,
    ST_LO_KICK,
    ST_LO_RUN,
    ST_SW_KICK,
    ST_SW_RUN,
    ST_PL_W,
    ST_PL_R,
    ST_HI_KICK,
    ST_HI_RUN,
    ST_DONE
  } mst_state_e;

  typedef enum logic [1:0] {
    FC_OK     = 2'b00,
    FC_LOW    = 2'b01,
    FC_HIGH   = 2'b10,
    FC_UNTEST = 2'b11
  } fault_code_e;

endpackage

// File: rtl/mst_walker.sv
// Address/pattern walker: for each pattern it steps through the addresses
// (either both corners or all words), spending one write cycle and one
// read-back cycle on each address.
module mst_walker #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sweep,
  input  logic              two_pat,
  output logic [ADDR_W-1:0] addr,
  output logic              pat,
  output logic              rd,
  output logic              active,
  output logic              last
);
  localparam logic [ADDR_W-1:0] LAST_A = '1;

  logic sweep_q;
  logic two_q;
  logic pat_end;

  assign pat_end = pat | ~two_q;
  assign last    = active & rd & (addr == LAST_A) & pat_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd      <= 1'b0;
      pat     <= 1'b0;
      addr    <= '0;
      sweep_q <= 1'b0;
      two_q   <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      rd      <= 1'b0;
      pat     <= 1'b0;
      addr    <= '0;
      sweep_q <= sweep;
      two_q   <= two_pat;
    end else if (active) begin
      rd <= ~rd;
      if (rd) begin
        if (addr == LAST_A) begin
          addr <= '0;
          if (pat_end) active <= 1'b0;
          else         pat    <= 1'b1;
        end else begin
          addr <= sweep_q ? addr + 1'b1 : LAST_A;
        end
      end
    end
  end
endmodule

// File: rtl/mst_judge.sv
// Per-slice compare of read data against the word that was written.
module mst_judge #(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 3
) (
  input  logic [SLICE_W*N_SLICES-1:0] rdata,
  input  logic [SLICE_W*N_SLICES-1:0] expect_w,
  output logic [N_SLICES-1:0]         lo_miss,
  output logic [N_SLICES-1:0]         hi_miss
);
  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    logic [SLICE_W-1:0] r_nib;
    logic [SLICE_W-1:0] e_nib;
    assign r_nib      = rdata[s*SLICE_W +: SLICE_W];
    assign e_nib      = expect_w[s*SLICE_W +: SLICE_W];
    assign lo_miss[s] = |(e_nib & ~r_nib);
    assign hi_miss[s] = |(~e_nib & r_nib);
  end
endmodule

// File: rtl/mst_status.sv
// Active-low status flags and sticky fault codes.
module mst_status
  import mst_pkg::*;
#(
  parameter int N_SLICES = 3,
  localparam int SL_W    = (N_SLICES > 1) ? $clog2(N_SLICES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd,
  input  logic [SL_W-1:0]       upd_slice,
  input  logic                  upd_bad,
  input  fault_code_e           upd_kind,
  input  logic                  set_untest,
  input  logic                  set_can,
  input  logic                  full_on,
  input  logic                  full_off,
  output logic [N_SLICES-1:0]   slice_ok_n,
  output logic [2*N_SLICES-1:0] fault_code,
  output logic                  can_test_n,
  output logic                  full_run_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_run_n <= 1'b0;
      can_test_n <= 1'b0;
    end else begin
      if (full_on)         full_run_n <= 1'b0;
      else if (full_off)   full_run_n <= 1'b1;
      if (set_untest)      can_test_n <= 1'b1;
      else if (set_can)    can_test_n <= 1'b0;
    end
  end

  for (genvar s = 0; s < N_SLICES; s++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slice_ok_n[s]         <= 1'b0;
        fault_code[2*s +: 2]  <= FC_OK;
      end else if (set_untest) begin
        slice_ok_n[s]         <= 1'b1;
        fault_code[2*s +: 2]  <= FC_UNTEST;
      end else if (upd && (upd_slice == SL_W'(s))) begin
        slice_ok_n[s] <= upd_bad;
        if (upd_bad && (fault_code[2*s +: 2] == FC_OK))
          fault_code[2*s +: 2] <= upd_kind;
      end
    end
  end
endmodule

// File: rtl/nibble_ram_selftest.sv
module nibble_ram_selftest
  import mst_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [SLICE_W*N_SLICES-1:0]   mem_wdata,
  output logic                          mem_we,
  input  logic [SLICE_W*N_SLICES-1:0]   mem_rdata,
  output logic [N_SLICES-1:0]           slice_ok_n,
  output logic                          full_run_n,
  output logic                          can_test_n,
  output logic [2*N_SLICES-1:0]         fault_code,
  output logic                          loop_done
);
  localparam int DATA_W = SLICE_W * N_SLICES;
  localparam int SL_W   = (N_SLICES > 1) ? $clog2(N_SLICES) : 1;
  localparam int PASS_W = $clog2(N_SLICES + 1);
  localparam logic [PASS_W-1:0] PASS_INIT  = PASS_W'(N_SLICES);
  localparam logic [SL_W-1:0]   SLICE_LAST = SL_W'(N_SLICES - 1);

  function automatic logic [SLICE_W-1:0] alt_nib(input logic odd);
    logic [SLICE_W-1:0] n;
    for (int i = 0; i < SLICE_W; i++) n[i] = ((i % 2) == 1) ? odd : ~odd;
    return n;
  endfunction

  function automatic logic [DATA_W-1:0] place(input logic [SLICE_W-1:0] nib,
                                              input logic [SL_W-1:0] s);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int k = 0; k < N_SLICES; k++)
      if (s == SL_W'(k)) w[k*SLICE_W +: SLICE_W] = nib;
    return w;
  endfunction

  localparam logic [SLICE_W-1:0] PAT_A = alt_nib(1'b0);
  localparam logic [SLICE_W-1:0] PAT_B = alt_nib(1'b1);

  mst_state_e        state_q, state_d;
  logic [SL_W-1:0]   slice_q, slice_d;
  logic              bad_q, bad_d;
  logic [PASS_W-1:0] pass_q, pass_d;

  logic              w_start, w_sweep, w_two;
  logic [ADDR_W-1:0] w_addr;
  logic              w_pat, w_rd, w_active, w_last;

  logic [DATA_W-1:0]   lo_word, hi_word, cmp_word;
  logic [N_SLICES-1:0] lo_miss, hi_miss;
  logic                verdict;
  logic [PASS_W-1:0]   pass_after;

  logic        st_upd, st_bad, st_untest, st_can, st_full_on, st_full_off;
  fault_code_e st_kind;

  mst_walker #(.ADDR_W(ADDR_W)) i_walker (
    .clk(clk), .rst_n(rst_n), .start(w_start), .sweep(w_sweep), .two_pat(w_two),
    .addr(w_addr), .pat(w_pat), .rd(w_rd), .active(w_active), .last(w_last)
  );

  mst_judge #(.SLICE_W(SLICE_W), .N_SLICES(N_SLICES)) i_judge (
    .rdata(mem_rdata), .expect_w(cmp_word), .lo_miss(lo_miss), .hi_miss(hi_miss)
  );

  mst_status #(.N_SLICES(N_SLICES)) i_status (
    .clk(clk), .rst_n(rst_n), .upd(st_upd), .upd_slice(slice_q), .upd_bad(st_bad),
    .upd_kind(st_kind), .set_untest(st_untest), .set_can(st_can),
    .full_on(st_full_on), .full_off(st_full_off), .slice_ok_n(slice_ok_n),
    .fault_code(fault_code), .can_test_n(can_test_n), .full_run_n(full_run_n)
  );

  assign lo_word   = place(w_pat ? PAT_B : PAT_A, slice_q);
  assign hi_word   = ~place('1, slice_q);
  assign cmp_word  = (state_q == ST_HI_RUN) ? hi_word : lo_word;
  assign verdict   = bad_q | ((state_q == ST_HI_RUN) ? hi_miss[slice_q] : lo_miss[slice_q]);
  assign pass_after = verdict ? pass_q : pass_q - 1'b1;
  assign loop_done = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    slice_d = slice_q;
    bad_d   = bad_q;
    pass_d  = pass_q;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    w_start = 1'b0;
    w_sweep = 1'b0;
    w_two   = 1'b0;
    st_upd = 1'b0;
    st_bad = verdict;
    st_kind = FC_LOW;
    st_untest = 1'b0;
    st_can = 1'b0;
    st_full_on = 1'b0;
    st_full_off = 1'b0;
    unique case (state_q)
      ST_START: begin
        pass_d      = PASS_INIT;
        st_full_off = 1'b1;
        state_d     = ST_PH_W;
      end
      ST_PH_W: begin
        mem_we  = 1'b1;
        state_d = ST_PH_R;
      end
      ST_PH_R: begin
        if (|mem_rdata) begin
          state_d = ST_PL_W;
        end else begin
          st_can  = 1'b1;
          slice_d = '0;
          state_d = ST_LO_KICK;
        end
      end
      ST_PL_W: begin
        mem_we    = 1'b1;
        mem_wdata = '1;
        state_d   = ST_PL_R;
      end
      ST_PL_R: begin
        if (!(&mem_rdata)) begin
          st_untest = 1'b1;
          state_d   = ST_DONE;
        end else begin
          st_can  = 1'b1;
          slice_d = '0;
          state_d = ST_HI_KICK;
        end
      end
      ST_LO_KICK, ST_SW_KICK, ST_HI_KICK: begin
        w_start = 1'b1;
        w_sweep = (state_q == ST_SW_KICK);
        w_two   = (state_q != ST_HI_KICK);
        bad_d   = 1'b0;
        state_d = (state_q == ST_LO_KICK) ? ST_LO_RUN :
                  (state_q == ST_SW_KICK) ? ST_SW_RUN : ST_HI_RUN;
      end
      ST_LO_RUN, ST_SW_RUN, ST_HI_RUN: begin
        mem_we    = w_active & ~w_rd;
        mem_addr  = w_addr;
        mem_wdata = cmp_word;
        if (w_rd) bad_d = verdict;
        if (w_last) begin
          st_upd  = 1'b1;
          st_kind = (state_q == ST_HI_RUN) ? FC_HIGH : FC_LOW;
          if (state_q == ST_LO_RUN) pass_d = pass_after;
          if (slice_q != SLICE_LAST) begin
            slice_d = slice_q + 1'b1;
            state_d = (state_q == ST_LO_RUN) ? ST_LO_KICK :
                      (state_q == ST_SW_RUN) ? ST_SW_KICK : ST_HI_KICK;
          end else if ((state_q == ST_LO_RUN) && (pass_after == '0)) begin
            slice_d    = '0;
            st_full_on = 1'b1;
            state_d    = ST_SW_KICK;
          end else begin
            st_full_off = (state_q == ST_SW_RUN);
            state_d     = ST_DONE;
          end
        end
      end
      ST_DONE: state_d = ST_START;
      default: state_d = ST_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      slice_q <= '0;
      bad_q   <= 1'b0;
      pass_q  <= '0;
    end else begin
      state_q <= state_d;
      slice_q <= slice_d;
      bad_q   <= bad_d;
      pass_q  <= pass_d;
    end
  end
endmodule

// File: rtl/mst_checker.sv
module mst_checker #(
  parameter int ADDR_W   = 8,
  parameter int N_SLICES = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mem_we,
  input logic [ADDR_W-1:0]     mem_addr,
  input logic [N_SLICES-1:0]   slice_ok_n,
  input logic                  full_run_n,
  input logic                  can_test_n,
  input logic [2*N_SLICES-1:0] fault_code,
  input logic                  loop_done
);
  a_r2_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we && $stable(mem_addr)));

  a_r7_corners_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && full_run_n) |-> (mem_addr == '0 || mem_addr == '1));

  a_r7_sweep_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_run_n) |-> (slice_ok_n == '0 && !can_test_n));

  a_r6_untest_all_bad: assert property (@(posedge clk) disable iff (!rst_n)
    can_test_n |-> (slice_ok_n == '1));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |=> !loop_done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |-> (full_run_n && !mem_we));

  for (genvar s = 0; s < N_SLICES; s++) begin : g_sticky
    a_r9_code_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_code[2*s +: 2] != 2'b00) |=> (fault_code[2*s +: 2] != 2'b00));
  end
endmodule

bind nibble_ram_selftest mst_checker #(.ADDR_W(ADDR_W), .N_SLICES(N_SLICES)) i_mst_checker (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .slice_ok_n(slice_ok_n), .full_run_n(full_run_n), .can_test_n(can_test_n),
  .fault_code(fault_code), .loop_done(loop_done)
);

// File: tb/test_nibble_ram_selftest.sv
module test_nibble_ram_selftest;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [11:0] mem_wdata;
  logic        mem_we;
  logic [11:0] mem_rdata;
  logic [2:0]  slice_ok_n;
  logic        full_run_n, can_test_n, loop_done;
  logic [5:0]  fault_code;

  always #5 clk = ~clk;

  nibble_ram_selftest i_nibble_ram_selftest (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .slice_ok_n(slice_ok_n),
    .full_run_n(full_run_n), .can_test_n(can_test_n),
    .fault_code(fault_code), .loop_done(loop_done)
  );

  // memory model with fault injection
  logic [11:0] mem [256];
  logic [11:0] sh_mask = '0, sl_mask = '0, pt_mask = '0;
  logic [7:0]  pt_addr = '0;
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
  always_comb begin
    mem_rdata = (mem[mem_addr] | sh_mask) & ~sl_mask;
    if (mem_addr == pt_addr) mem_rdata = mem_rdata & ~pt_mask;
  end

  int checks = 0, failures = 0;
  int r2_viol = 0, r10_viol = 0;
  bit sweep_seen = 0;
  logic prev_we = 0, prev_done = 0;
  logic [7:0] prev_addr = '0;

  typedef struct {
    logic [2:0] ok;
    logic [5:0] codes;
    logic       can;
    string      tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!loop_done);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push_and_wait(input logic [2:0] ok, input logic [5:0] codes,
                               input logic can, input string tag);
    exp_t e;
    @(negedge clk);
    sweep_seen = 0;
    e.ok = ok; e.codes = codes; e.can = can; e.tag = tag;
    q.push_back(e);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic run_case(input logic [11:0] sh, input logic [11:0] sl,
                          input logic [7:0] pa, input logic [11:0] pm,
                          input logic [2:0] ok, input logic [5:0] codes,
                          input logic can, input bit exp_sweep, input string tag);
    sh_mask = sh; sl_mask = sl; pt_addr = pa; pt_mask = pm;
    do_reset();
    wait_strobe();
    push_and_wait(ok, codes, can, tag);
    chk({tag, " R7"}, "sweep ran", 32'(sweep_seen), 32'(exp_sweep));
  endtask

  // monitor: scoreboard compare at loop end
  always @(negedge clk) begin
    if (rst_n) begin
      if (!full_run_n) sweep_seen = 1;
      if (prev_we && (mem_we || mem_addr != prev_addr)) r2_viol++;
      if (prev_done && loop_done) r10_viol++;
      if (loop_done) begin
        chk("R10", "full_run_n at loop end", 32'(full_run_n), 32'd1);
        if (q.size() != 0) begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, "slice_ok_n", 32'(slice_ok_n), 32'(e.ok));
          chk(e.tag, "fault_code", 32'(fault_code), 32'(e.codes));
          chk(e.tag, "can_test_n", 32'(can_test_n), 32'(e.can));
        end
      end
    end
    prev_we = mem_we; prev_addr = mem_addr; prev_done = loop_done;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", "slice_ok_n", 32'(slice_ok_n), 32'd0);
    chk("R1", "full_run_n", 32'(full_run_n), 32'd0);
    chk("R1", "can_test_n", 32'(can_test_n), 32'd0);
    chk("R1", "fault_code", 32'(fault_code), 32'd0);
    chk("R1", "mem_we/loop_done", 32'({mem_we, loop_done}), 32'd0);
    // clean memory: sweep runs, all good (R8, R11)
    run_case(12'h000, 12'h000, 8'h00, 12'h000, 3'b000, 6'b000000, 1'b0, 1, "R11 clean");
    // stuck-low bit 1, low slice (R4)
    run_case(12'h000, 12'h002, 8'h00, 12'h000, 3'b001, 6'b000001, 1'b0, 0, "R4 low slice");
    // stuck-low bit 9, high slice (R4)
    run_case(12'h000, 12'h200, 8'h00, 12'h000, 3'b100, 6'b010000, 1'b0, 0, "R4 high slice");
    // stuck-high bit 6 sends to high branch (R3, R5)
    run_case(12'h040, 12'h000, 8'h00, 12'h000, 3'b010, 6'b001000, 1'b0, 0, "R3 R5 mid slice");
    // stuck-high bits 0 and 11 (R5)
    run_case(12'h801, 12'h000, 8'h00, 12'h000, 3'b101, 6'b100010, 1'b0, 0, "R5 two slices");
    // combined fault -> untestable (R6)
    run_case(12'h004, 12'h020, 8'h00, 12'h000, 3'b111, 6'b111111, 1'b1, 0, "R6 untestable");
    // single-address fault only seen by sweep (R8)
    run_case(12'h000, 12'h000, 8'h80, 12'h010, 3'b010, 6'b000100, 1'b0, 1, "R8 point fault");
    // sticky code after fault removal (R9)
    run_case(12'h000, 12'h001, 8'h00, 12'h000, 3'b001, 6'b000001, 1'b0, 0, "R9 before");
    sl_mask = '0;
    wait_strobe();
    wait_strobe();
    push_and_wait(3'b000, 6'b000001, 1'b0, "R9 after removal");
    chk("R9 R7", "sweep ran after recovery", 32'(sweep_seen), 32'd1);
    chk("R2", "write not followed by read", 32'(r2_viol), 32'd0);
    chk("R10", "loop_done longer than one cycle", 32'(r10_viol), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule